// File: doc/BRIEF.md
# Two-Bank IN Endpoint Packet Buffer

This block is the transmit-side packet store for a bulk or interrupt IN endpoint of a USB device controller. It holds two banks of `DEPTH` bytes each. The processor fills the bank it currently owns one byte at a time. It then writes a byte count, which hands that bank to the serial engine and arms it for transmission. While one bank waits or is being sent, the processor can already fill the other bank.

For each IN token, the serial side gets a one-cycle response: data, NAK or STALL, or nothing at all when the endpoint is disabled. A data response carries the packet length and the data PID. The bytes of the oldest armed bank are then offered one per read strobe. A host ACK frees that bank, flips the data PID and raises the buffer-available flag. A timeout leaves the bank armed, so the same packet is sent again. Because there are two banks, the buffer-available flag survives the first count write after reset and only drops on the second.

Top module: `inep_dualbank`

## Requirements
- R1: After reset, `bav_flag`=1, `nak_flag`=0, `stall_q`=0, `disable_q`=0, `data_pid`=0 (DATA0) and `rsp_valid`=0.
- R2: A count write arms the processor-owned bank only while fewer than two banks are armed. When both are armed, count writes and byte writes are ignored: queued packets, their contents and the flags stay unchanged.
- R3: The buffer-available flag starts set. A count write that arms the first bank leaves it set. A count write that arms the second bank clears it. An ACK that frees a bank sets it. Writing 1 to `cpu_bav_w1c` clears it, but a set event in the same cycle wins.
- R4: Consider an IN token with a bank armed, no stall and no disable. One cycle later `rsp_valid`=1, `rsp_code`=1 (DATA), `rsp_pid` holds the current PID, and `rsp_len` holds the armed count limited to `DEPTH`. `tx_byte` then shows the bytes in write order and advances by one on each `usb_rd`.
- R5: Armed banks are transmitted strictly in the order they were armed.
- R6: An ACK after a data response frees the sent bank and inverts `data_pid`. An ACK with no data response outstanding changes nothing.
- R7: After `usb_timeout`, the next IN token resends the same bank with the same PID.
- R8: While `stall_q`=1, every IN token gets `rsp_code`=3 (STALL), whether or not a bank is armed. Clearing the stall bit restores data and NAK responses.
- R9: While `disable_q`=1, an IN token gets no response (`rsp_valid` stays 0) and no flag changes. Disable takes priority over stall.
- R10: An IN token with no armed bank, no stall and no disable gets `rsp_code`=2 (NAK) and sets `nak_flag`. Writing 1 to `cpu_nak_w1c` clears the flag, but a NAK in the same cycle wins.
- R11: A pulse on `cpu_tog_clr` forces `data_pid` to 0, so the next data response is DATA0. It acts once only: later ACKs invert the PID again.
- R12: A count of 0 arms a bank as a zero-length packet: DATA with `rsp_len`=0, which consumes the bank when ACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_byte_we | input | 1 | Write one byte into the processor-owned bank |
| cpu_byte | input | DW | Byte to write |
| cpu_cnt_we | input | 1 | Byte-count write; arms the owned bank |
| cpu_cnt | input | LEN_W | Byte count of the packet |
| cpu_ctl_we | input | 1 | Load the stall and disable bits |
| cpu_stall | input | 1 | Stall value to load |
| cpu_disable | input | 1 | Disable value to load |
| cpu_tog_clr | input | 1 | Force the data PID to DATA0 |
| cpu_bav_w1c | input | 1 | Clear the buffer-available flag |
| cpu_nak_w1c | input | 1 | Clear the NAK-observed flag |
| bav_flag | output | 1 | Buffer-available flag |
| nak_flag | output | 1 | NAK-observed flag |
| stall_q | output | 1 | Stall bit |
| disable_q | output | 1 | Disable bit |
| data_pid | output | 1 | PID for the next data packet (0 = DATA0) |
| usb_in_tok | input | 1 | IN token addressed to this endpoint |
| usb_ack | input | 1 | Host ACK for the last data packet |
| usb_timeout | input | 1 | No handshake arrived for the last data packet |
| usb_rd | input | 1 | Advance to the next packet byte |
| rsp_valid | output | 1 | Response strobe, one cycle after the token |
| rsp_code | output | 2 | 1 DATA, 2 NAK, 3 STALL |
| rsp_len | output | LEN_W | Packet length for a DATA response |
| rsp_pid | output | 1 | Data PID of the DATA response |
| tx_byte | output | DW | Current packet byte |

## Verification
The bench targets the flag behaviour after reset. A design that tracked only one bank would drop the buffer-available flag on the first count write; one that never counted would keep it set after the second. It loads a third packet while both banks are armed. A design without that guard would overwrite the bank being sent or reorder packets. Timeouts must resend the same bytes with an unflipped PID. Stray ACKs must not flip the PID. Set-versus-clear collisions on both flags must leave the flag set. Zero-length and over-long counts must come back as length 0 and `DEPTH` respectively.

// File: rtl/inep_pkg.sv
package inep_pkg;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DATA  = 2'd1,
    RSP_NAK   = 2'd2,
    RSP_STALL = 2'd3
  } rsp_e;

  // sticky flag: a set event beats a clear event in the same cycle
  function automatic logic flag_next(input logic set_ev, input logic clr_ev, input logic cur);
    return set_ev | (cur & ~clr_ev);
  endfunction

endpackage

// File: rtl/inep_bank_mem.sv
module inep_bank_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] rd_word [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
    end
    assign rd_word[b] = mem[rd_addr];
  end

  assign rd_data = rd_word[rd_bank];

endmodule

// File: rtl/inep_bank_ctl.sv
module inep_bank_ctl #(
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_we,
  input  logic             cnt_we,
  input  logic [LEN_W-1:0] cnt_val,
  input  logic             free_evt,
  output logic             cnt_ok,
  output logic             fill_ok,
  output logic             fill_bank,
  output logic [AW-1:0]    fill_addr,
  output logic             head_bank,
  output logic [LEN_W-1:0] head_len,
  output logic [1:0]       armed
);

  logic [LEN_W-1:0] fill_ptr;
  logic [LEN_W-1:0] len_q [2];

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    return (v > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : v;
  endfunction

  assign cnt_ok    = cnt_we && (armed != 2'd2);
  assign fill_ok   = byte_we && (armed != 2'd2) && (fill_ptr < LEN_W'(DEPTH));
  assign fill_addr = fill_ptr[AW-1:0];
  assign head_len  = len_q[head_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_ptr  <= '0;
      fill_bank <= 1'b0;
      head_bank <= 1'b0;
      armed     <= 2'd0;
      len_q[0]  <= '0;
      len_q[1]  <= '0;
    end else begin
      if (cnt_ok) begin
        len_q[fill_bank] <= clamp_len(cnt_val);
        fill_bank        <= ~fill_bank;
        fill_ptr         <= '0;
      end else if (fill_ok) begin
        fill_ptr <= fill_ptr + 1'b1;
      end
      if (free_evt) head_bank <= ~head_bank;
      armed <= armed + {1'b0, cnt_ok} - {1'b0, free_evt};
    end
  end

endmodule

// File: rtl/inep_tok_rsp.sv
module inep_tok_rsp
  import inep_pkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_in,
  input  logic             ack,
  input  logic             timeout,
  input  logic             rd_step,
  input  logic             tog_clr,
  input  logic             dis,
  input  logic             stall,
  input  logic [1:0]       armed,
  input  logic [LEN_W-1:0] head_len,
  output logic             rsp_valid,
  output rsp_e             rsp_code,
  output logic [LEN_W-1:0] rsp_len,
  output logic             rsp_pid,
  output logic [AW-1:0]    rd_addr,
  output logic             free_evt,
  output logic             nak_evt,
  output logic             in_flight,
  output logic             pid
);

  rsp_e code_n;

  always_comb begin
    code_n = RSP_NONE;
    if (tok_in && !dis) begin
      if (stall)               code_n = RSP_STALL;
      else if (armed == 2'd0)  code_n = RSP_NAK;
      else                     code_n = RSP_DATA;
    end
  end

  assign free_evt = ack && in_flight;
  assign nak_evt  = (code_n == RSP_NAK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_NONE;
      rsp_len   <= '0;
      rsp_pid   <= 1'b0;
      rd_addr   <= '0;
      in_flight <= 1'b0;
      pid       <= 1'b0;
    end else begin
      rsp_valid <= (code_n != RSP_NONE);
      rsp_code  <= code_n;
      rsp_len   <= (code_n == RSP_DATA) ? head_len : '0;
      rsp_pid   <= (code_n == RSP_DATA) ? pid : 1'b0;
      if (code_n == RSP_DATA) rd_addr <= '0;
      else if (rd_step)       rd_addr <= rd_addr + 1'b1;
      if (ack || timeout)     in_flight <= 1'b0;
      if (code_n == RSP_DATA) in_flight <= 1'b1;
      if (tog_clr)            pid <= 1'b0;
      else if (free_evt)      pid <= ~pid;
    end
  end

endmodule

// File: rtl/inep_dualbank.sv
module inep_dualbank
  import inep_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DW     = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_byte_we,
  input  logic [DW-1:0]    cpu_byte,
  input  logic             cpu_cnt_we,
  input  logic [LEN_W-1:0] cpu_cnt,
  input  logic             cpu_ctl_we,
  input  logic             cpu_stall,
  input  logic             cpu_disable,
  input  logic             cpu_tog_clr,
  input  logic             cpu_bav_w1c,
  input  logic             cpu_nak_w1c,
  output logic             bav_flag,
  output logic             nak_flag,
  output logic             stall_q,
  output logic             disable_q,
  output logic             data_pid,
  input  logic             usb_in_tok,
  input  logic             usb_ack,
  input  logic             usb_timeout,
  input  logic             usb_rd,
  output logic             rsp_valid,
  output logic [1:0]       rsp_code,
  output logic [LEN_W-1:0] rsp_len,
  output logic             rsp_pid,
  output logic [DW-1:0]    tx_byte
);

  logic             cnt_ok, fill_ok, fill_bank, head_bank;
  logic [AW-1:0]    fill_addr, rd_addr;
  logic [LEN_W-1:0] head_len;
  logic [1:0]       armed;
  logic             free_evt, nak_evt, in_flight, pid;
  rsp_e             rsp_q;
  logic             bav_set, bav_clr;

  inep_bank_ctl #(.DEPTH(DEPTH)) i_ctl (
    .clk(clk), .rst_n(rst_n),
    .byte_we(cpu_byte_we), .cnt_we(cpu_cnt_we), .cnt_val(cpu_cnt),
    .free_evt(free_evt),
    .cnt_ok(cnt_ok), .fill_ok(fill_ok), .fill_bank(fill_bank), .fill_addr(fill_addr),
    .head_bank(head_bank), .head_len(head_len), .armed(armed)
  );

  inep_bank_mem #(.DEPTH(DEPTH), .DW(DW)) i_mem (
    .clk(clk),
    .wr_en(fill_ok), .wr_bank(fill_bank), .wr_addr(fill_addr), .wr_data(cpu_byte),
    .rd_bank(head_bank), .rd_addr(rd_addr), .rd_data(tx_byte)
  );

  inep_tok_rsp #(.DEPTH(DEPTH)) i_rsp (
    .clk(clk), .rst_n(rst_n),
    .tok_in(usb_in_tok), .ack(usb_ack), .timeout(usb_timeout), .rd_step(usb_rd),
    .tog_clr(cpu_tog_clr), .dis(disable_q), .stall(stall_q),
    .armed(armed), .head_len(head_len),
    .rsp_valid(rsp_valid), .rsp_code(rsp_q), .rsp_len(rsp_len), .rsp_pid(rsp_pid),
    .rd_addr(rd_addr), .free_evt(free_evt), .nak_evt(nak_evt),
    .in_flight(in_flight), .pid(pid)
  );

  assign rsp_code = rsp_q;
  assign data_pid = pid;

  // arming the first of two banks keeps a bank free, so the flag reappears at once
  assign bav_set = free_evt || (cnt_ok && (armed == 2'd0));
  assign bav_clr = cnt_ok || cpu_bav_w1c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bav_flag  <= 1'b1;
      nak_flag  <= 1'b0;
      stall_q   <= 1'b0;
      disable_q <= 1'b0;
    end else begin
      bav_flag <= flag_next(bav_set, bav_clr, bav_flag);
      nak_flag <= flag_next(nak_evt, cpu_nak_w1c, nak_flag);
      if (cpu_ctl_we) begin
        stall_q   <= cpu_stall;
        disable_q <= cpu_disable;
      end
    end
  end

endmodule

// File: rtl/inep_dualbank_chk.sv
module inep_dualbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_in,
  input logic       ack,
  input logic       tog_clr,
  input logic       dis,
  input logic       stall,
  input logic [1:0] armed,
  input logic       fill_bank,
  input logic       head_bank,
  input logic       in_flight,
  input logic       free_evt,
  input logic       pid,
  input logic       rsp_valid,
  input logic [1:0] rsp_code,
  input logic       nak_flag,
  input logic       bav_flag
);

  // R2
  armed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed != 2'd3);

  // R5
  bank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_bank == (head_bank ^ armed[0]));

  // R4
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(tok_in));

  // R9
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && dis) |=> !rsp_valid);

  // R8
  stall_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && !dis && stall) |=> (rsp_code == 2'd3));

  // R10
  nak_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && !dis && !stall && armed == 2'd0) |=> (nak_flag && rsp_code == 2'd2));

  // R3
  bav_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_evt |=> bav_flag);

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_evt && !tog_clr) |=> (pid != $past(pid)));

  // R6
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !in_flight && !tog_clr) |=> $stable(pid));

  // R11
  tog_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tog_clr |=> !pid);

endmodule

bind inep_dualbank inep_dualbank_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tok_in(usb_in_tok), .ack(usb_ack), .tog_clr(cpu_tog_clr),
  .dis(disable_q), .stall(stall_q), .armed(armed), .fill_bank(fill_bank),
  .head_bank(head_bank), .in_flight(in_flight), .free_evt(free_evt), .pid(pid),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .nak_flag(nak_flag), .bav_flag(bav_flag)
);

// File: tb/test_inep_dualbank.sv
module test_inep_dualbank;

  localparam int DEPTH = 64;
  localparam int DW    = 8;
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_byte_we = 0, cpu_cnt_we = 0, cpu_ctl_we = 0, cpu_stall = 0, cpu_disable = 0;
  logic cpu_tog_clr = 0, cpu_bav_w1c = 0, cpu_nak_w1c = 0;
  logic [DW-1:0] cpu_byte = '0;
  logic [LEN_W-1:0] cpu_cnt = '0;
  logic usb_in_tok = 0, usb_ack = 0, usb_timeout = 0, usb_rd = 0;
  logic bav_flag, nak_flag, stall_q, disable_q, data_pid, rsp_valid, rsp_pid;
  logic [1:0] rsp_code;
  logic [LEN_W-1:0] rsp_len;
  logic [DW-1:0] tx_byte;

  always #2 clk = ~clk;

  inep_dualbank #(.DEPTH(DEPTH), .DW(DW)) i_inep_dualbank (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  int m_armed = 0, m_head = 0, m_pid = 0, m_bav = 1, m_nak = 0, m_stall = 0, m_dis = 0, m_infl = 0;
  int pk_len [2];
  int pk_wn  [2];
  logic [DW-1:0] pk_dat [2][DEPTH];

  function automatic int exp_len(int cnt);
    return (cnt > DEPTH) ? DEPTH : cnt;
  endfunction

  function automatic int exp_code();
    if (m_dis != 0) return 0;
    if (m_stall != 0) return 3;
    if (m_armed == 0) return 2;
    return 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_flags(string req);
    check({req, " bav"}, int'(bav_flag), m_bav);
    check({req, " nak"}, int'(nak_flag), m_nak);
    check({req, " pid"}, int'(data_pid), m_pid);
  endtask

  task automatic load_pkt(int nbytes, int cnt);
    int slot = (m_head + m_armed) % 2;
    bit owned = (m_armed < 2);
    for (int i = 0; i < nbytes; i++) begin
      cpu_byte_we = 1; cpu_byte = DW'($urandom);
      if (owned && i < DEPTH) pk_dat[slot][i] = cpu_byte;
      tick();
    end
    cpu_byte_we = 0;
    cpu_cnt_we = 1; cpu_cnt = LEN_W'(cnt);
    tick();
    cpu_cnt_we = 0;
    if (owned) begin
      pk_len[slot] = exp_len(cnt);
      pk_wn[slot]  = (nbytes > DEPTH) ? DEPTH : nbytes;
      m_bav = (m_armed == 0) ? 1 : 0;
      m_armed++;
    end
    check_flags("R3 load");
  endtask

  task automatic token(bit nclr);
    int ec = exp_code();
    usb_in_tok = 1; cpu_nak_w1c = nclr;
    tick();
    usb_in_tok = 0; cpu_nak_w1c = 0;
    if (nclr) m_nak = 0;
    if (ec == 2) m_nak = 1;
    if (ec == 0) begin
      check("R9 no response", int'(rsp_valid), 0);
    end else begin
      check("R4 rsp_valid", int'(rsp_valid), 1);
      check(ec == 3 ? "R8 stall code" : (ec == 2 ? "R10 nak code" : "R4 data code"),
            int'(rsp_code), ec);
    end
    check("R10 nak flag", int'(nak_flag), m_nak);
    if (ec == 1) begin
      m_infl = 1;
      check("R4 len", int'(rsp_len), pk_len[m_head]);
      check("R6 rsp pid", int'(rsp_pid), m_pid);
      for (int i = 0; i < pk_len[m_head]; i++) begin
        if (i < pk_wn[m_head]) check("R5 byte order", int'(tx_byte), int'(pk_dat[m_head][i]));
        usb_rd = 1; tick(); usb_rd = 0;
      end
    end
  endtask

  task automatic ack(bit bclr);
    usb_ack = 1; cpu_bav_w1c = bclr;
    tick();
    usb_ack = 0; cpu_bav_w1c = 0;
    if (bclr) m_bav = 0;
    if (m_infl != 0) begin
      m_head = (m_head + 1) % 2; m_armed--; m_pid ^= 1; m_bav = 1;
    end
    m_infl = 0;
    check_flags("R6 ack");
  endtask

  task automatic tmo();
    usb_timeout = 1; tick(); usb_timeout = 0;
    m_infl = 0;
  endtask

  task automatic ctl(int st, int ds);
    cpu_ctl_we = 1; cpu_stall = st[0]; cpu_disable = ds[0];
    tick();
    cpu_ctl_we = 0;
    m_stall = st; m_dis = ds;
    check("R8 stall bit", int'(stall_q), st);
    check("R9 disable bit", int'(disable_q), ds);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1 bav", int'(bav_flag), 1);
    check("R1 nak", int'(nak_flag), 0);
    check("R1 stall", int'(stall_q), 0);
    check("R1 disable", int'(disable_q), 0);
    check("R1 pid", int'(data_pid), 0);
    check("R1 rsp_valid", int'(rsp_valid), 0);

    // R10 NAK with nothing armed; clear, then set-wins collision
    token(0);
    cpu_nak_w1c = 1; tick(); cpu_nak_w1c = 0; m_nak = 0;
    check("R10 w1c", int'(nak_flag), 0);
    token(1);

    // R3 flag survives first load, drops on second; R2 third load ignored
    load_pkt(5, 5);
    load_pkt(70, 100);
    load_pkt(3, 3);
    check("R2 full bav", int'(bav_flag), 0);

    // R7 timeout resend, R5 order, R6 ack
    token(0);
    tmo();
    check("R7 pid kept", int'(data_pid), m_pid);
    token(0);
    ack(1);            // R3 set beats w1c
    ack(0);            // R6 stray ack ignored
    token(0);
    ack(0);

    // R12 zero-length
    load_pkt(0, 0);
    token(0);
    check("R12 zero len", int'(rsp_len), 0);
    ack(0);
    check("R12 consumed", int'(bav_flag), 1);
    token(0);

    // R11 toggle clear
    cpu_tog_clr = 1; tick(); cpu_tog_clr = 0; m_pid = 0;
    check("R11 pid cleared", int'(data_pid), 0);
    load_pkt(2, 2);
    token(0);
    ack(0);
    check("R11 flips after", int'(data_pid), 1);

    // R8 stall, R9 disable priority
    load_pkt(4, 4);
    ctl(1, 0); token(0);
    ctl(1, 1); token(0);
    ctl(0, 0); token(0); ack(0);

    // random mix
    for (int it = 0; it < 500; it++) begin
      int r = $urandom_range(0, 9);
      if (r <= 2) begin
        int n = $urandom_range(0, 66);
        load_pkt(n, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 127) : n);
      end else if (r <= 5) token($urandom_range(0, 3) == 0);
      else if (r <= 7) ack($urandom_range(0, 3) == 0);
      else if (r == 8) tmo();
      else ctl(($urandom_range(0, 4) == 0) ? 1 : 0, ($urandom_range(0, 5) == 0) ? 1 : 0);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule